// File: doc/BRIEF.md
# Pipelined Burst SRAM Front End

This block is a synthesizable behavioural model of the control and datapath front end of a synchronous pipelined burst SRAM. Every input is captured on the rising clock edge. A burst opens on either of two address strobes. One strobe comes from the controller side and the other from the processor side. An access is taken only when all three chip enables are active. After the start, a 2-bit counter walks the two low address bits. The counter steps only on cycles with the advance input asserted. The step order is linear or interleaved, chosen by a mode pin.

Each word is made of byte lanes of nine bits: eight data bits plus one parity bit. A write can touch every lane at once through the global write input. Otherwise it touches a chosen subset of lanes through a byte-write enable combined with per-lane selects. Any accepted cycle that writes no lane is a read. Read data reaches the output register one clock after its address was registered. After the last read, the data stays driven for one more cycle before the output is released. The output enable gates the drive combinationally. The undriven bus is modelled as a drive flag plus data forced to zero.

Top module: `sram_fe_top`

## Requirements
- R1: While reset is low and after it is released, `rd_drive_o` is 0, `rd_data_o` is zero, and no burst is open until a new strobe starts one.
- R2: With `oe_n` high, `rd_drive_o` is 0 and `rd_data_o` is zero. Lowering `oe_n` drives the held read data in the same cycle, with no clock edge in between.
- R3: A strobe (`adsc_n` or `adsp_n` low) with all of `ce_a_n`, `ce_b_n`, `ce_c_n` low loads `addr_i` and starts a burst. The word read at that address appears on `rd_data_o` after the next rising edge. That is one clock after the address was registered.
- R4: Inside a burst, a cycle with no strobe steps the counter only when `adv_n` is low. With `adv_n` high, the same address is accessed again.
- R5: With `mode_i` low at burst start, the two low address bits are (start bits + count) mod 4, where count is the number of advances. The upper address bits stay fixed for the whole burst.
- R6: With `mode_i` high at burst start, the two low address bits are the start bits XOR the count. The mode is sampled only on the start cycle.
- R7: On an accepted cycle, `gw_n` low writes all lanes from `wr_data_i`, whatever `bwe_n` and `bw_n` are.
- R8: Without global write, lane i (bits [9i+8:9i], bit 9i+8 being its parity) is written only when `bwe_n` is low and `bw_n[i]` is low. The other lanes keep their old contents. `bw_n` has no effect while `bwe_n` is high.
- R9: An accepted cycle that writes no lane is a read. Write cycles do not reload the output register.
- R10: A strobe with any chip enable high deselects the block. That cycle performs no access and ends the open burst.
- R11: The chip enables are ignored on cycles with no strobe. A burst continues whatever their values are.
- R12: After the last read, the output stays driven with the held data for one further cycle, and is then released.
- R13: When both strobes are low, the controller strobe wins. A burst started by the processor strobe alone is a read on its start cycle, even if write controls are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address, loaded on burst start |
| adsc_n | input | 1 | Controller-side address strobe, active low, higher priority |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_a_n | input | 1 | Chip enable A, active low |
| ce_b_n | input | 1 | Chip enable B, active low |
| ce_c_n | input | 1 | Chip enable C, active low |
| mode_i | input | 1 | Burst order at start: 0 linear, 1 interleaved |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, combinational |
| wr_data_i | input | 9*LANES | Write data, lane i in bits [9i+8:9i] |
| rd_data_o | output | 9*LANES | Read data, zero when not driven |
| rd_drive_o | output | 1 | High when the read data is driven |

## Verification
The bench walks linear and interleaved bursts that wrap past the end of the 4-word group. A counter that carried into the upper address bits, or that XORed in the wrong mode, returns the neighbour word. It holds the address with advance high, toggles chip enables mid-burst, and deselects with each enable in turn. A design that stepped regardless of advance, or that honoured enables without a strobe, would misplace the data. Partial lane writes, byte selects without the byte-write enable, and global write with every select off would leave wrong lanes or parity bits. The bench also drives both strobes at once with global write asserted, checks the release one cycle late after deselect, and changes the output enable between edges.

// File: rtl/sram_fe_pkg.sv
package sram_fe_pkg;
  localparam int LANE_BITS = 9;

  // low address bits of a burst step for a start value and advance count
  function automatic logic [1:0] burst_lo(input logic interleave,
                                          input logic [1:0] start,
                                          input logic [1:0] count);
    return interleave ? (start ^ count) : (start + count);
  endfunction
endpackage

// File: rtl/sram_fe_burst.sv
module sram_fe_burst #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adsc_n,
  input  logic              adsp_n,
  input  logic              adv_n,
  input  logic [2:0]        ce_n,
  input  logic              mode_i,
  output logic              acc_now,
  output logic              proc_start,
  output logic              in_burst,
  output logic [ADDR_W-1:0] addr_q
);
  import sram_fe_pkg::*;

  logic              strobe, sel_ok, start, kill;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              ilv_q;

  assign strobe     = !adsc_n || !adsp_n;
  assign sel_ok     = (ce_n == 3'b000);
  assign start      = strobe && sel_ok;
  assign kill       = strobe && !sel_ok;
  assign acc_now    = start || (!strobe && in_burst);
  assign proc_start = start && adsc_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      cnt_q    <= '0;
      ilv_q    <= 1'b0;
      in_burst <= 1'b0;
    end else if (start) begin
      base_q   <= addr_i;
      cnt_q    <= '0;
      ilv_q    <= mode_i;
      in_burst <= 1'b1;
    end else if (kill) begin
      in_burst <= 1'b0;
    end else if (in_burst && !adv_n) begin
      cnt_q <= cnt_q + 2'd1;
    end
  end

  assign addr_q = {base_q[ADDR_W-1:2], burst_lo(ilv_q, base_q[1:0], cnt_q)};
endmodule

// File: rtl/sram_fe_wdec.sv
module sram_fe_wdec #(
  parameter int LANES = 4
) (
  input  logic             acc_now,
  input  logic             proc_start,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output logic [LANES-1:0] lane_we
);
  logic wr_ok;
  assign wr_ok = acc_now && !proc_start;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_we[i] = wr_ok && (!gw_n || (!bwe_n && !bw_n[i]));
  end
endmodule

// File: rtl/sram_fe_array.sv
module sram_fe_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [ADDR_W-1:0]                     addr_q,
  input  logic [LANES-1:0]                      wmask_q,
  input  logic [sram_fe_pkg::LANE_BITS*LANES-1:0] wdata_q,
  input  logic                                  rd_q,
  output logic [sram_fe_pkg::LANE_BITS*LANES-1:0] dout_q
);
  import sram_fe_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_BITS-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (wmask_q[i]) store[addr_q] <= wdata_q[i*LANE_BITS +: LANE_BITS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dout_q[i*LANE_BITS +: LANE_BITS] <= '0;
      else if (rd_q) dout_q[i*LANE_BITS +: LANE_BITS] <= store[addr_q];
    end
  end
endmodule

// File: rtl/sram_fe_drive.sv
module sram_fe_drive #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_q,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] dout_q,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_drive_o
);
  logic live_q, tail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      tail_q <= 1'b0;
    end else begin
      live_q <= rd_q;
      tail_q <= live_q;
    end
  end

  assign rd_drive_o = (live_q || tail_q) && !oe_n;
  assign rd_data_o  = rd_drive_o ? dout_q : '0;
endmodule

// File: rtl/sram_fe_top.sv
module sram_fe_top #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      adsc_n,
  input  logic                      adsp_n,
  input  logic                      adv_n,
  input  logic                      ce_a_n,
  input  logic                      ce_b_n,
  input  logic                      ce_c_n,
  input  logic                      mode_i,
  input  logic                      gw_n,
  input  logic                      bwe_n,
  input  logic [LANES-1:0]          bw_n,
  input  logic                      oe_n,
  input  logic [9*LANES-1:0]        wr_data_i,
  output logic [9*LANES-1:0]        rd_data_o,
  output logic                      rd_drive_o
);
  localparam int DATA_W = sram_fe_pkg::LANE_BITS * LANES;

  logic              acc_now, proc_start, in_burst;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  lane_we, wmask_q;
  logic [DATA_W-1:0] wdata_q, dout_q;
  logic              rd_q;

  sram_fe_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .adsc_n(adsc_n), .adsp_n(adsp_n),
    .adv_n(adv_n), .ce_n({ce_c_n, ce_b_n, ce_a_n}), .mode_i(mode_i),
    .acc_now(acc_now), .proc_start(proc_start), .in_burst(in_burst), .addr_q(addr_q)
  );

  sram_fe_wdec #(.LANES(LANES)) u_wdec (
    .acc_now(acc_now), .proc_start(proc_start), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .lane_we(lane_we)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wmask_q <= '0;
      wdata_q <= '0;
      rd_q    <= 1'b0;
    end else begin
      wmask_q <= lane_we;
      wdata_q <= wr_data_i;
      rd_q    <= acc_now && (lane_we == '0);
    end
  end

  sram_fe_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
    .clk(clk), .rst_n(rst_n), .addr_q(addr_q), .wmask_q(wmask_q),
    .wdata_q(wdata_q), .rd_q(rd_q), .dout_q(dout_q)
  );

  sram_fe_drive #(.DATA_W(DATA_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .rd_q(rd_q), .oe_n(oe_n), .dout_q(dout_q),
    .rd_data_o(rd_data_o), .rd_drive_o(rd_drive_o)
  );
endmodule

// File: rtl/sram_fe_chk.sv
module sram_fe_chk #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 adsc_n,
  input logic                 adsp_n,
  input logic                 adv_n,
  input logic                 ce_a_n,
  input logic                 ce_b_n,
  input logic                 ce_c_n,
  input logic                 oe_n,
  input logic                 rd_drive_o,
  input logic [9*LANES-1:0]   rd_data_o,
  input logic                 in_burst,
  input logic [ADDR_W-1:0]    addr_q,
  input logic                 rd_q,
  input logic [LANES-1:0]     wmask_q
);
  logic any_strobe, all_sel;
  assign any_strobe = !adsc_n || !adsp_n;
  assign all_sel    = !ce_a_n && !ce_b_n && !ce_c_n;

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !rd_drive_o);

  p_oe_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rd_drive_o);

  p_undriven_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_drive_o |-> (rd_data_o == '0));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_burst && !any_strobe && adv_n) |=> $stable(addr_q));

  p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_burst && !any_strobe) |=> $stable(addr_q[ADDR_W-1:2]));

  p_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (any_strobe && !all_sel) |=> (!rd_q && wmask_q == '0 && !in_burst));

  p_proc_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && adsc_n && all_sel) |=> (wmask_q == '0 && rd_q));
endmodule

bind sram_fe_top sram_fe_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .adsc_n(adsc_n), .adsp_n(adsp_n), .adv_n(adv_n),
  .ce_a_n(ce_a_n), .ce_b_n(ce_b_n), .ce_c_n(ce_c_n), .oe_n(oe_n),
  .rd_drive_o(rd_drive_o), .rd_data_o(rd_data_o), .in_burst(in_burst),
  .addr_q(addr_q), .rd_q(rd_q), .wmask_q(wmask_q)
);

// File: tb/sram_fe_top_tb_top.sv
module sram_fe_top_tb_top;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int DW = 9 * NL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic adsc_n = 1'b1, adsp_n = 1'b1, adv_n = 1'b1;
  logic ce_a_n = 1'b0, ce_b_n = 1'b0, ce_c_n = 1'b0;
  logic mode_i = 1'b0, gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
  logic [NL-1:0] bw_n = '1;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic rd_drive_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sram_fe_top #(.ADDR_W(AW), .LANES(NL)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .adsc_n(adsc_n), .adsp_n(adsp_n),
    .adv_n(adv_n), .ce_a_n(ce_a_n), .ce_b_n(ce_b_n), .ce_c_n(ce_c_n),
    .mode_i(mode_i), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .rd_drive_o(rd_drive_o)
  );

  localparam logic [DW-1:0] W8  = 36'h1_2345_6708;
  localparam logic [DW-1:0] W9  = 36'h2_3456_7809;
  localparam logic [DW-1:0] WA  = 36'h3_4567_890A;
  localparam logic [DW-1:0] WB  = 36'h4_5678_9A0B;
  localparam logic [DW-1:0] XD  = 36'h5_AAAA_BBBB;
  localparam logic [DW-1:0] LM  = 36'h0_07FC_01FF; // lanes 0 and 2
  localparam logic [DW-1:0] MRG = (XD & LM) | (WA & ~LM);
  localparam logic [DW-1:0] YD  = 36'hF_0F0F_0F0F;
  localparam logic [DW-1:0] ZD  = 36'h9_8765_4321;
  localparam logic [DW-1:0] QD  = 36'h0_0000_0001;
  localparam logic [DW-1:0] ONE = '1;

  typedef struct packed {
    logic          adsp_n, adsc_n, adv_n;
    logic [2:0]    ce_n;   // {c,b,a}
    logic          mode, gw_n, bwe_n;
    logic [NL-1:0] bw_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    logic          edrv;
    logic [DW-1:0] edata;
    logic [3:0]    req;
  } vec_t;

  // expected values are the outputs after this vector's clock edge
  localparam vec_t TBL [32] = '{
    '{1'b1,1'b0,1'b1,3'b000,1'b0,1'b0,1'b1,4'hF,6'h08,W8 ,1'b0,'0 ,4'd7},  // R7 gw burst write
    '{1'b1,1'b1,1'b0,3'b000,1'b0,1'b0,1'b1,4'hF,6'h00,W9 ,1'b0,'0 ,4'd4},  // R4
    '{1'b1,1'b1,1'b0,3'b000,1'b0,1'b0,1'b1,4'hF,6'h00,WA ,1'b0,'0 ,4'd4},
    '{1'b1,1'b1,1'b0,3'b000,1'b0,1'b0,1'b1,4'hF,6'h00,WB ,1'b0,'0 ,4'd4},
    '{1'b1,1'b0,1'b1,3'b010,1'b0,1'b1,1'b1,4'hF,6'h00,'0 ,1'b0,'0 ,4'd10}, // R10
    '{1'b1,1'b0,1'b1,3'b000,1'b0,1'b1,1'b1,4'hF,6'h0A,'0 ,1'b0,'0 ,4'd3},  // R3 read start
    '{1'b1,1'b1,1'b0,3'b000,1'b0,1'b1,1'b1,4'hF,6'h00,'0 ,1'b1,WA ,4'd3},
    '{1'b1,1'b1,1'b0,3'b111,1'b0,1'b1,1'b1,4'hF,6'h00,'0 ,1'b1,WB ,4'd11}, // R11
    '{1'b1,1'b1,1'b0,3'b000,1'b0,1'b1,1'b1,4'hF,6'h00,'0 ,1'b1,W8 ,4'd5},  // R5 wrap
    '{1'b1,1'b0,1'b1,3'b001,1'b0,1'b1,1'b1,4'hF,6'h00,'0 ,1'b1,W9 ,4'd5},
    '{1'b1,1'b1,1'b1,3'b000,1'b0,1'b1,1'b1,4'hF,6'h00,'0 ,1'b1,W9 ,4'd12}, // R12
    '{1'b1,1'b1,1'b1,3'b000,1'b0,1'b1,1'b1,4'hF,6'h00,'0 ,1'b0,'0 ,4'd12},
    '{1'b0,1'b1,1'b1,3'b000,1'b1,1'b1,1'b1,4'hF,6'h09,'0 ,1'b0,'0 ,4'd6},  // R6
    '{1'b1,1'b1,1'b0,3'b000,1'b1,1'b1,1'b1,4'hF,6'h00,'0 ,1'b1,W9 ,4'd6},
    '{1'b1,1'b1,1'b0,3'b000,1'b1,1'b1,1'b1,4'hF,6'h00,'0 ,1'b1,W8 ,4'd6},
    '{1'b1,1'b1,1'b0,3'b000,1'b1,1'b1,1'b1,4'hF,6'h00,'0 ,1'b1,WB ,4'd6},
    '{1'b1,1'b1,1'b1,3'b000,1'b1,1'b1,1'b1,4'hF,6'h00,'0 ,1'b1,WA ,4'd6},
    '{1'b0,1'b1,1'b1,3'b100,1'b1,1'b1,1'b1,4'hF,6'h00,'0 ,1'b1,WA ,4'd4},  // R4 hold
    '{1'b1,1'b1,1'b1,3'b000,1'b0,1'b1,1'b1,4'hF,6'h00,'0 ,1'b1,WA ,4'd12},
    '{1'b1,1'b1,1'b1,3'b000,1'b0,1'b1,1'b1,4'hF,6'h00,'0 ,1'b0,'0 ,4'd12},
    '{1'b1,1'b0,1'b1,3'b000,1'b0,1'b1,1'b0,4'hA,6'h0A,XD ,1'b0,'0 ,4'd8},  // R8 lanes 0,2
    '{1'b1,1'b1,1'b1,3'b000,1'b0,1'b1,1'b1,4'h0,6'h00,ONE,1'b0,'0 ,4'd9},  // R9 read
    '{1'b1,1'b1,1'b1,3'b000,1'b0,1'b0,1'b1,4'hF,6'h00,YD ,1'b1,MRG,4'd8},
    '{1'b1,1'b1,1'b1,3'b000,1'b0,1'b1,1'b1,4'hF,6'h00,'0 ,1'b1,MRG,4'd9},
    '{1'b1,1'b0,1'b1,3'b010,1'b0,1'b1,1'b1,4'hF,6'h00,'0 ,1'b1,YD ,4'd7},
    '{1'b1,1'b1,1'b1,3'b000,1'b0,1'b1,1'b1,4'hF,6'h00,'0 ,1'b1,YD ,4'd12},
    '{1'b1,1'b1,1'b1,3'b000,1'b0,1'b1,1'b1,4'hF,6'h00,'0 ,1'b0,'0 ,4'd12},
    '{1'b0,1'b0,1'b1,3'b000,1'b0,1'b0,1'b1,4'hF,6'h0C,ZD ,1'b0,'0 ,4'd13}, // R13
    '{1'b0,1'b1,1'b1,3'b000,1'b0,1'b0,1'b1,4'hF,6'h0C,QD ,1'b0,'0 ,4'd13},
    '{1'b1,1'b0,1'b1,3'b011,1'b0,1'b1,1'b1,4'hF,6'h00,'0 ,1'b1,ZD ,4'd13},
    '{1'b1,1'b1,1'b1,3'b000,1'b0,1'b1,1'b1,4'hF,6'h00,'0 ,1'b1,ZD ,4'd12},
    '{1'b1,1'b1,1'b1,3'b000,1'b0,1'b1,1'b1,4'hF,6'h00,'0 ,1'b0,'0 ,4'd12}
  };

  task automatic check(input string tag, input logic drv, input logic [DW-1:0] dat);
    n_run++;
    if (rd_drive_o !== drv || rd_data_o !== dat) begin
      n_fail++;
      $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
               tag, rd_drive_o, rd_data_o, drv, dat);
    end
  endtask

  task automatic idle();
    adsc_n = 1'b1; adsp_n = 1'b1; adv_n = 1'b1;
    {ce_c_n, ce_b_n, ce_a_n} = 3'b000;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1; wr_data_i = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, '0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 after release", 1'b0, '0);

    for (int i = 0; i < 32; i++) begin
      adsp_n = TBL[i].adsp_n; adsc_n = TBL[i].adsc_n; adv_n = TBL[i].adv_n;
      {ce_c_n, ce_b_n, ce_a_n} = TBL[i].ce_n;
      mode_i = TBL[i].mode; gw_n = TBL[i].gw_n; bwe_n = TBL[i].bwe_n;
      bw_n = TBL[i].bw_n; addr_i = TBL[i].addr; wr_data_i = TBL[i].wd;
      @(posedge clk); @(negedge clk);
      check($sformatf("R%0d vector %0d", TBL[i].req, i), TBL[i].edrv, TBL[i].edata);
    end

    // R2: output enable gates the drive without a clock edge
    oe_n = 1'b1; adsc_n = 1'b0; addr_i = 6'h0C; mode_i = 1'b0;
    @(posedge clk); @(negedge clk);
    idle();
    @(posedge clk); @(negedge clk);
    check("R2 oe high hides data", 1'b0, '0);
    oe_n = 1'b0; #1;
    check("R2 oe low drives", 1'b1, ZD);
    oe_n = 1'b1; #1;
    check("R2 oe high again", 1'b0, '0);
    oe_n = 1'b0;

    // R1: reset mid-burst closes it
    rst_n = 1'b0; #1;
    check("R1 async reset", 1'b0, '0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check("R1 no burst after reset", 1'b0, '0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule